// File: doc/BRIEF.md
# UART Interrupt Enable and Source Arbitration

This block turns the event and level conditions of a UART into one interrupt request line for the host. Six sources can raise it: received data, transmit space, line status error changes, modem status changes, a received flow-control stop character, and a rising edge on the request-to-send output. The host controls each source through a 7-bit enable register. The three upper enable bits (sleep, stop-character and request-to-send) only act while an enhanced-features input is set. When a FIFO-enable input is set, the receive and transmit conditions compare the FIFO fill levels against programmed trigger levels. When it is clear, the block works with single-character holding registers.

Each source has a pending flag. The receive flag simply follows its level condition. Every other flag is set by an event and stays set until the host acknowledges it. The block reports which pending source ranks highest through a 3-bit identifier. Writing zero to the four basic enable bits gives polled operation: the host reads status directly and no interrupt is raised from those sources. The block does not decode registers and does not gate clocks. It does drive out the effective sleep enable so that the clocking logic can use it.

Top module: `uart_irq_top`

## Requirements
- R1: After reset the enable register is zero, `irq` is low, `srcId` is 0 and `sleepEn` is low.
- R2: With enable bit 0 set, receive data is pending while the condition holds. Without FIFOs the condition is `rxLevel != 0`; with FIFOs it is `rxLevel >= rxTrigger`. The pending state drops one cycle after the condition goes away.
- R3: With enable bit 1 set, transmit ready becomes pending when the transmit condition becomes true. Without FIFOs the condition is `txLevel == 0`; with FIFOs it is `txLevel < txTrigger`. It also becomes pending within two cycles of enable bit 1 being written to 1 while the condition is already true.
- R4: A pending transmit ready is cleared by a `txWrite` pulse, or by an `idRead` pulse while `srcId` is 3. It is not raised again until the condition rises again.
- R5: With enable bit 2 set, any change of the 4-bit `lsrBits` sets line status pending one cycle later, and `lsrRead` clears it. A change in the same cycle as `lsrRead` leaves it pending.
- R6: With enable bit 3 set, a `msrChange` pulse sets modem status pending, and `msrRead` clears it.
- R7: While `enhEnable` is 0, enable bits 4 to 6 have no effect. `sleepEn` stays low, and stop-character and request-to-send events raise nothing and leave nothing pending.
- R8: With `enhEnable` set, enable bit 5 lets an `xoffEvent` pulse set pending and enable bit 6 lets a low-to-high edge of `rtsLevel` set pending. Either one is cleared by `idRead` while it is the reported source. `sleepEn` equals enable bit 4.
- R9: `srcId` reports the highest-ranked source that is both pending and enabled: 1 line status, 2 receive data, 3 transmit ready, 4 modem status, 5 stop character, 6 request-to-send, 0 none. Rank follows that order, with 1 highest. `irq` is high exactly when `srcId` is not 0.
- R10: Clearing a source's enable bit withdraws its request at once and discards its pending state. Enabling it again does not bring the old event back.
- R11: With enable bits 0 to 3 clear and the upper bits clear or not in effect, `irq` stays low whatever the FIFO levels, status changes and events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enWrite | input | 1 | Load `enData` into the enable register |
| enData | input | 7 | New enable register value |
| enhEnable | input | 1 | Enhanced features on; unlocks enable bits 4 to 6 |
| fifoEnable | input | 1 | FIFO mode for receive and transmit conditions |
| rxLevel | input | LVL_W | Receive FIFO or holding register fill |
| rxTrigger | input | LVL_W | Programmed receive trigger level |
| txLevel | input | LVL_W | Transmit FIFO or holding register fill |
| txTrigger | input | LVL_W | Programmed transmit trigger level |
| lsrBits | input | 4 | Current line status error bits |
| lsrRead | input | 1 | Host read of line status; acknowledges that source |
| msrChange | input | 1 | Pulse: a modem status input changed |
| msrRead | input | 1 | Host read of modem status; acknowledges that source |
| xoffEvent | input | 1 | Pulse: stop character received |
| rtsLevel | input | 1 | Present level of the request-to-send output |
| txWrite | input | 1 | Host write to the transmit path |
| idRead | input | 1 | Host read of the source identifier |
| irq | output | 1 | Interrupt request |
| srcId | output | 3 | Highest-ranked pending source |
| sleepEn | output | 1 | Effective sleep enable |

## Verification
Two things can fall in the same cycle: a new line status change that sets the flag, and the host's `lsrRead` that clears it. The bench provokes this by changing `lsrBits` and pulsing `lsrRead` on the same clock. It passes only if line status is still reported after that clock, and only a further read alone clears it. A second overlap gets the same treatment: all four basic sources are raised on one clock, and the bench checks that they come out one at a time in rank order as each is acknowledged.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // enable register layout (bit positions are host-visible)
  localparam int EN_W     = 7;
  localparam int EN_BASIC = 4;
  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int EN_SLEEP = 4;
  localparam int EN_XOFF  = 5;
  localparam int EN_RTS   = 6;

  // source indices in rank order, 0 = highest
  localparam int NUM_SRC   = 6;
  localparam int IDX_W     = $clog2(NUM_SRC);
  localparam int IDX_LINE  = 0;
  localparam int IDX_RX    = 1;
  localparam int IDX_TX    = 2;
  localparam int IDX_MODEM = 3;
  localparam int IDX_XOFF  = 4;
  localparam int IDX_RTS   = 5;

  typedef enum logic [2:0] {
    SRC_NONE    = 3'd0,
    SRC_LINE    = 3'd1,
    SRC_RXDATA  = 3'd2,
    SRC_TXREADY = 3'd3,
    SRC_MODEM   = 3'd4,
    SRC_XOFF    = 3'd5,
    SRC_RTS     = 3'd6
  } srcId_e;

  // control -> datapath strobes
  typedef struct packed {
    logic [NUM_SRC-1:0] clr;    // acknowledge per source
    logic [NUM_SRC-1:0] allow;  // effective enable per source
  } strobe_t;

endpackage

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 6,
  parameter int LSR_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic               fifoEnable,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic [LVL_W-1:0]   rxTrigger,
  input  logic [LVL_W-1:0]   txLevel,
  input  logic [LVL_W-1:0]   txTrigger,
  input  logic [LSR_W-1:0]   lsrBits,
  input  logic               msrChange,
  input  logic               xoffEvent,
  input  logic               rtsLevel,
  output logic [NUM_SRC-1:0] pending
);

  logic [LSR_W-1:0]   lsrPrev;
  logic               rtsPrev;
  logic               txCondQ;
  logic               txAllowQ;
  logic               rxCond;
  logic               txCond;
  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] nextPend;

  // level conditions, FIFO or holding-register flavour
  always_comb begin
    if (fifoEnable) begin
      rxCond = (rxLevel >= rxTrigger);
      txCond = (txLevel < txTrigger);
    end else begin
      rxCond = (rxLevel != '0);
      txCond = (txLevel == '0);
    end
  end

  // event detection
  always_comb begin
    setVec            = '0;
    setVec[IDX_LINE]  = (lsrBits != lsrPrev);
    setVec[IDX_RX]    = rxCond;
    // rising condition, or enable newly granted while condition holds
    setVec[IDX_TX]    = txCond & (~txCondQ | ~txAllowQ);
    setVec[IDX_MODEM] = msrChange;
    setVec[IDX_XOFF]  = xoffEvent;
    setVec[IDX_RTS]   = rtsLevel & ~rtsPrev;
  end

  // next pending state: receive follows its level, others latch
  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      if (s == IDX_RX) begin
        nextPend[s] = setVec[s] & ~strobe.clr[s] & strobe.allow[s];
      end else begin
        nextPend[s] = ((pending[s] & ~strobe.clr[s]) | setVec[s]) & strobe.allow[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lsrPrev  <= '0;
      rtsPrev  <= 1'b0;
      txCondQ  <= 1'b0;
      txAllowQ <= 1'b0;
      pending  <= '0;
    end else begin
      lsrPrev  <= lsrBits;
      rtsPrev  <= rtsLevel;
      txCondQ  <= txCond;
      txAllowQ <= strobe.allow[IDX_TX];
      pending  <= nextPend;
    end
  end

endmodule

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               enWrite,
  input  logic [EN_W-1:0]    enData,
  input  logic               enhEnable,
  input  logic               idRead,
  input  logic               txWrite,
  input  logic               lsrRead,
  input  logic               msrRead,
  input  logic [NUM_SRC-1:0] pending,
  output strobe_t            strobe,
  output logic [EN_W-1:0]    enReg,
  output logic               sleepEn,
  output logic               irq,
  output srcId_e             srcId
);

  logic [EN_W-1:0]    effEn;
  logic [NUM_SRC-1:0] live;
  logic [IDX_W-1:0]   topIdx;
  logic               found;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg <= '0;
    end else if (enWrite) begin
      enReg <= enData;
    end
  end

  // upper bits are locked out unless enhanced features are on
  for (genvar b = 0; b < EN_W; b++) begin : g_eff
    if (b < EN_BASIC) begin : g_basic
      assign effEn[b] = enReg[b];
    end else begin : g_upper
      assign effEn[b] = enReg[b] & enhEnable;
    end
  end

  assign sleepEn = effEn[EN_SLEEP];

  always_comb begin
    strobe.allow            = '0;
    strobe.allow[IDX_LINE]  = effEn[EN_LINE];
    strobe.allow[IDX_RX]    = effEn[EN_RX];
    strobe.allow[IDX_TX]    = effEn[EN_TX];
    strobe.allow[IDX_MODEM] = effEn[EN_MODEM];
    strobe.allow[IDX_XOFF]  = effEn[EN_XOFF];
    strobe.allow[IDX_RTS]   = effEn[EN_RTS];
  end

  assign live = pending & strobe.allow;

  // fixed-rank selection: lowest index wins
  always_comb begin
    found  = 1'b0;
    topIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (live[i]) begin
        found  = 1'b1;
        topIdx = IDX_W'(i);
      end
    end
  end

  assign srcId = found ? srcId_e'(topIdx + IDX_W'(1)) : SRC_NONE;
  assign irq   = found;

  always_comb begin
    strobe.clr            = '0;
    strobe.clr[IDX_LINE]  = lsrRead;
    strobe.clr[IDX_MODEM] = msrRead;
    strobe.clr[IDX_TX]    = txWrite | (idRead && srcId == SRC_TXREADY);
    strobe.clr[IDX_XOFF]  = idRead && srcId == SRC_XOFF;
    strobe.clr[IDX_RTS]   = idRead && srcId == SRC_RTS;
  end

endmodule

// File: rtl/uart_irq_top.sv
module uart_irq_top
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enWrite,
  input  logic [6:0]       enData,
  input  logic             enhEnable,
  input  logic             fifoEnable,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] rxTrigger,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] txTrigger,
  input  logic [3:0]       lsrBits,
  input  logic             lsrRead,
  input  logic             msrChange,
  input  logic             msrRead,
  input  logic             xoffEvent,
  input  logic             rtsLevel,
  input  logic             txWrite,
  input  logic             idRead,
  output logic             irq,
  output logic [2:0]       srcId,
  output logic             sleepEn
);

  strobe_t            strobe;
  logic [NUM_SRC-1:0] pending;
  logic [EN_W-1:0]    enReg;
  srcId_e             srcIdE;

  uart_irq_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .enWrite   (enWrite),
    .enData    (enData),
    .enhEnable (enhEnable),
    .idRead    (idRead),
    .txWrite   (txWrite),
    .lsrRead   (lsrRead),
    .msrRead   (msrRead),
    .pending   (pending),
    .strobe    (strobe),
    .enReg     (enReg),
    .sleepEn   (sleepEn),
    .irq       (irq),
    .srcId     (srcIdE)
  );

  uart_irq_dp #(.LVL_W(LVL_W), .LSR_W(4)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fifoEnable (fifoEnable),
    .rxLevel    (rxLevel),
    .rxTrigger  (rxTrigger),
    .txLevel    (txLevel),
    .txTrigger  (txTrigger),
    .lsrBits    (lsrBits),
    .msrChange  (msrChange),
    .xoffEvent  (xoffEvent),
    .rtsLevel   (rtsLevel),
    .pending    (pending)
  );

  assign srcId = srcIdE;

endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk #(
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             irq,
  input logic [2:0]       srcId,
  input logic             sleepEn,
  input logic             enhEnable,
  input logic [6:0]       enReg,
  input logic             enWrite,
  input logic             fifoEnable,
  input logic [LVL_W-1:0] rxLevel,
  input logic [LVL_W-1:0] rxTrigger,
  input logic [3:0]       lsrBits
);

  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  AST_IRQ_HAS_ID: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> srcId != 3'd0);  // R9

  AST_QUIET_NO_ID: assert property (@(posedge clk) disable iff (!rstN)
    !irq |-> srcId == 3'd0);  // R9

  AST_UPPER_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !enhEnable |-> (srcId < 3'd5) && !sleepEn);  // R7

  AST_POLLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (enReg[3:0] == 4'd0 && (!enhEnable || enReg[6:4] == 3'd0)) |-> !irq);  // R11

  AST_RX_TRIGGER_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (enReg[0] && !enWrite && fifoEnable && rxLevel >= rxTrigger) |=> irq);  // R2

  AST_LINE_CHANGE_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (armed && enReg[2] && !enWrite && lsrBits != $past(lsrBits)) |=> irq);  // R5

endmodule

bind uart_irq_top uart_irq_chk #(.LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .irq        (irq),
  .srcId      (srcId),
  .sleepEn    (sleepEn),
  .enhEnable  (enhEnable),
  .enReg      (enReg),
  .enWrite    (enWrite),
  .fifoEnable (fifoEnable),
  .rxLevel    (rxLevel),
  .rxTrigger  (rxTrigger),
  .lsrBits    (lsrBits)
);

// File: tb/uart_irq_top_test.sv
module uart_irq_top_test;

  localparam int LVL_W = 6;
  localparam logic [2:0] ID_NONE = 3'd0, ID_LINE = 3'd1, ID_RX = 3'd2,
                         ID_TX = 3'd3, ID_MODEM = 3'd4, ID_XOFF = 3'd5, ID_RTS = 3'd6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enWrite = 1'b0;
  logic [6:0]       enData = '0;
  logic             enhEnable = 1'b0;
  logic             fifoEnable = 1'b0;
  logic [LVL_W-1:0] rxLevel = '0;
  logic [LVL_W-1:0] rxTrigger = '0;
  logic [LVL_W-1:0] txLevel = 6'd5;
  logic [LVL_W-1:0] txTrigger = '0;
  logic [3:0]       lsrBits = '0;
  logic             lsrRead = 1'b0;
  logic             msrChange = 1'b0;
  logic             msrRead = 1'b0;
  logic             xoffEvent = 1'b0;
  logic             rtsLevel = 1'b0;
  logic             txWrite = 1'b0;
  logic             idRead = 1'b0;
  logic             irq;
  logic [2:0]       srcId;
  logic             sleepEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_irq_top #(.LVL_W(LVL_W)) uut (
    .clk(clk), .rstN(rstN), .enWrite(enWrite), .enData(enData),
    .enhEnable(enhEnable), .fifoEnable(fifoEnable),
    .rxLevel(rxLevel), .rxTrigger(rxTrigger), .txLevel(txLevel), .txTrigger(txTrigger),
    .lsrBits(lsrBits), .lsrRead(lsrRead), .msrChange(msrChange), .msrRead(msrRead),
    .xoffEvent(xoffEvent), .rtsLevel(rtsLevel), .txWrite(txWrite), .idRead(idRead),
    .irq(irq), .srcId(srcId), .sleepEn(sleepEn)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic checkVal(input string req, input string what, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic expectId(input string req, input logic [2:0] id);
    checkVal(req, "srcId", int'(srcId), int'(id));
    checkVal(req, "irq", int'(irq), int'(id != ID_NONE));
  endtask

  task automatic writeEn(input logic [6:0] v);
    enData = v; enWrite = 1'b1;
    step(1);
    enWrite = 1'b0;
  endtask

  task automatic pulseIdRead();
    idRead = 1'b1; step(1); idRead = 1'b0;
  endtask

  task automatic testReset();
    expectId("R1", ID_NONE);
    checkVal("R1", "sleepEn", int'(sleepEn), 0);
  endtask

  task automatic testRxData();
    writeEn(7'h01);
    rxLevel = 6'd1; step(1);
    expectId("R2", ID_RX);
    rxLevel = 6'd0; step(1);
    expectId("R2", ID_NONE);
    fifoEnable = 1'b1; rxTrigger = 6'd8; rxLevel = 6'd7; step(1);
    expectId("R2", ID_NONE);
    rxLevel = 6'd8; step(1);
    expectId("R2", ID_RX);
    rxLevel = 6'd0; fifoEnable = 1'b0;
    writeEn(7'h00);
  endtask

  task automatic testTxReady();
    writeEn(7'h02); step(1);
    expectId("R3", ID_NONE);
    txLevel = 6'd0; step(1);
    expectId("R3", ID_TX);
    txWrite = 1'b1; step(1); txWrite = 1'b0;
    expectId("R4", ID_NONE);
    step(2);
    expectId("R4", ID_NONE);
    writeEn(7'h00);
    writeEn(7'h02); step(1);
    expectId("R3", ID_TX);   // enabled while already empty
    pulseIdRead();
    expectId("R4", ID_NONE);
    txLevel = 6'd4; txTrigger = 6'd4; fifoEnable = 1'b1; step(1);
    expectId("R3", ID_NONE);
    txLevel = 6'd3; step(1);
    expectId("R3", ID_TX);
    txWrite = 1'b1; step(1); txWrite = 1'b0;
    expectId("R4", ID_NONE);
    writeEn(7'h00);
    fifoEnable = 1'b0; txLevel = 6'd5; step(1);
  endtask

  task automatic testLineStatus();
    writeEn(7'h04);
    lsrBits = 4'b0001; step(1);
    expectId("R5", ID_LINE);
    lsrRead = 1'b1; step(1); lsrRead = 1'b0;
    expectId("R5", ID_NONE);
    lsrBits = 4'b0011; lsrRead = 1'b1; step(1); lsrRead = 1'b0;
    expectId("R5", ID_LINE);  // change and read in one cycle
    lsrRead = 1'b1; step(1); lsrRead = 1'b0;
    expectId("R5", ID_NONE);
    lsrBits = 4'b0010; step(1);
    expectId("R5", ID_LINE);  // a bit falling is also a change
    lsrRead = 1'b1; step(1); lsrRead = 1'b0;
    writeEn(7'h00);
  endtask

  task automatic testModem();
    writeEn(7'h08);
    msrChange = 1'b1; step(1); msrChange = 1'b0;
    expectId("R6", ID_MODEM);
    step(1);
    expectId("R6", ID_MODEM);
    msrRead = 1'b1; step(1); msrRead = 1'b0;
    expectId("R6", ID_NONE);
    writeEn(7'h00);
  endtask

  task automatic testUpperBits();
    enhEnable = 1'b0;
    writeEn(7'h70); step(1);
    checkVal("R7", "sleepEn", int'(sleepEn), 0);
    xoffEvent = 1'b1; step(1); xoffEvent = 1'b0;
    expectId("R7", ID_NONE);
    rtsLevel = 1'b1; step(1);
    expectId("R7", ID_NONE);
    rtsLevel = 1'b0; step(1);
    enhEnable = 1'b1; step(1);
    checkVal("R8", "sleepEn", int'(sleepEn), 1);
    expectId("R7", ID_NONE);   // nothing stored while locked
    xoffEvent = 1'b1; step(1); xoffEvent = 1'b0;
    expectId("R8", ID_XOFF);
    pulseIdRead();
    expectId("R8", ID_NONE);
    rtsLevel = 1'b1; step(1);
    expectId("R8", ID_RTS);
    pulseIdRead();
    expectId("R8", ID_NONE);
    step(1);
    expectId("R8", ID_NONE);   // high level alone does not re-raise
    rtsLevel = 1'b0;
    writeEn(7'h00);
    enhEnable = 1'b0; step(1);
  endtask

  task automatic testPriority();
    writeEn(7'h0F); step(1);
    expectId("R9", ID_NONE);
    lsrBits = 4'b0100; rxLevel = 6'd1; txLevel = 6'd0; msrChange = 1'b1;
    step(1); msrChange = 1'b0;
    expectId("R9", ID_LINE);
    lsrRead = 1'b1; step(1); lsrRead = 1'b0;
    expectId("R9", ID_RX);
    rxLevel = 6'd0; step(1);
    expectId("R9", ID_TX);
    pulseIdRead();
    expectId("R9", ID_MODEM);
    msrRead = 1'b1; step(1); msrRead = 1'b0;
    expectId("R9", ID_NONE);
    writeEn(7'h00);
    txLevel = 6'd5; step(1);
  endtask

  task automatic testDisable();
    writeEn(7'h08);
    msrChange = 1'b1; step(1); msrChange = 1'b0;
    expectId("R10", ID_MODEM);
    writeEn(7'h00);
    expectId("R10", ID_NONE);
    writeEn(7'h08); step(1);
    expectId("R10", ID_NONE);
    writeEn(7'h00);
  endtask

  task automatic testPolled();
    enhEnable = 1'b1;
    writeEn(7'h00);
    fifoEnable = 1'b1; rxTrigger = 6'd8; rxLevel = 6'd20; txTrigger = 6'd4; txLevel = 6'd0;
    lsrBits = 4'b1000; msrChange = 1'b1; xoffEvent = 1'b1; rtsLevel = 1'b1;
    step(1);
    msrChange = 1'b0; xoffEvent = 1'b0;
    step(1);
    expectId("R11", ID_NONE);
    checkVal("R11", "sleepEn", int'(sleepEn), 0);
    rxLevel = 6'd0; rtsLevel = 1'b0; fifoEnable = 1'b0; txLevel = 6'd5; enhEnable = 1'b0;
    step(1);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    testReset();
    testRxData();
    testTxReady();
    testLineStatus();
    testModem();
    testUpperBits();
    testPriority();
    testDisable();
    testPolled();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule